// File: doc/BRIEF.md
# Serial Port Interrupt Identification and FIFO Control

This block is the register-side control logic of a 16550-style serial port. It takes host writes to a FIFO control register and host reads of an interrupt identification value. The source conditions (line status, transmit holding empty, modem status and receive timeout) and the receive FIFO byte count arrive from the datapath as inputs. The block derives the receive data-ready condition from the count and the selected trigger level. It ranks the sources by a fixed priority and presents the winner as an 8-bit identification byte.

A FIFO control write can start a one-cycle flush pulse for either FIFO, which the datapath uses to empty that FIFO and zero its count. The shift registers are left alone. The same write also sets FIFO mode and the receive trigger level. The identification byte is a registered snapshot. While the host holds its read strobe, the snapshot is frozen, so sources that arrive during the access cannot change the byte being read.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Priority from highest to lowest is line status, then receive data ready, then receive timeout, then transmit holding empty, then modem status. Bits 3..1 of the identification byte read 011, 010, 110, 001 and 000 for these sources, in that order.
- R2: Bit 0 of the identification byte is 0 when any source is pending and 1 when none is. With nothing pending the byte reads 0x01 in non-FIFO mode and 0xC1 in FIFO mode. The output `irq` is 1 exactly when a source is pending.
- R3: A receive timeout is ranked only in FIFO mode. In non-FIFO mode it is ignored and bit 3 reads 0.
- R4: Bits 5 and 4 always read 0. Bits 7 and 6 both equal the FIFO-mode flag, which is control write bit 0.
- R5: The identification byte shows the ranking sampled at the most recent clock edge at which `iir_rd` was low. While `iir_rd` stays high the byte does not change. It updates at the first edge after the read ends.
- R6: A control write with bit 1 set raises `rx_flush` for exactly the one cycle after the write edge.
- R7: A control write with bit 2 set raises `tx_flush` for exactly the one cycle after the write edge. The two flush bits act independently.
- R8: Control write bits 7..6 select the receive trigger level: 00, 01, 10 and 11 give 1, 4, 8 and 14 bytes, shown on `rx_trig_bytes`. In FIFO mode, data ready is pending when `rx_count` is greater than or equal to that level.
- R9: In non-FIFO mode, data ready is pending when `rx_count` is nonzero, regardless of the trigger level.
- R10: Control write bits 5..3 have no effect. Mode, trigger level and flush outputs are unchanged by them.
- R11: After reset, the identification byte is 0x01, both flush outputs are 0, FIFO mode is off and the trigger level is 1 byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| iir_rd | input | 1 | Held high for the duration of an identification read |
| src_line | input | 1 | Receiver line status condition |
| src_thre | input | 1 | Transmit holding register empty condition |
| src_modem | input | 1 | Modem status condition |
| src_tout | input | 1 | Receive character timeout condition |
| rx_count | input | CNT_W | Receive FIFO byte count |
| iir_data | output | 8 | Interrupt identification byte |
| irq | output | 1 | Any source pending (live) |
| rx_flush | output | 1 | One-cycle receive FIFO flush pulse |
| tx_flush | output | 1 | One-cycle transmit FIFO flush pulse |
| fifo_en | output | 1 | FIFO mode flag |
| rx_trig_bytes | output | CNT_W | Selected receive trigger level in bytes |

## Verification
A wrong rank or a wrong mode flag appears in `iir_data` one clock after the inputs settle. A stale or leaking snapshot register shows on the first read whose sources change while `iir_rd` is high: the byte moves when it should hold. A stuck flush bit shows as a pulse that lasts two cycles, or as a pulse on the wrong FIFO, in the cycle after a write. A wrong trigger decode flips `irq` immediately when `rx_count` sits one below or at the selected level.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [2:0] ID_LINE  = 3'b011;
  localparam logic [2:0] ID_RXDAT = 3'b010;
  localparam logic [2:0] ID_TOUT  = 3'b110;
  localparam logic [2:0] ID_THRE  = 3'b001;
  localparam logic [2:0] ID_MODEM = 3'b000;

  localparam logic [7:0] IIR_RESET = 8'h01;

  // trigger code to byte count
  function automatic int unsigned trig_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // assemble identification byte: mode bits, zero bits, id, active-low pending
  function automatic logic [7:0] iir_pack(input logic fen, input logic pend,
                                          input logic [2:0] id);
    return {fen, fen, 2'b00, id, ~pend};
  endfunction
endpackage

// File: rtl/uart_fcr_regs.sv
module uart_fcr_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       fifo_en,
  output logic [1:0] trig_code,
  output logic       rx_flush,
  output logic       tx_flush
);
  logic unused_fcr_bits;
  assign unused_fcr_bits = ^wdata[5:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en   <= 1'b0;
      trig_code <= 2'b00;
      rx_flush  <= 1'b0;
      tx_flush  <= 1'b0;
    end else begin
      rx_flush <= wr & wdata[1];
      tx_flush <= wr & wdata[2];
      if (wr) begin
        fifo_en   <= wdata[0];
        trig_code <= wdata[7:6];
      end
    end
  end
endmodule

// File: rtl/uart_irq_rank.sv
module uart_irq_rank
  import uart_irq_pkg::*;
(
  input  logic       fifo_en,
  input  logic       s_line,
  input  logic       s_rxdat,
  input  logic       s_tout,
  input  logic       s_thre,
  input  logic       s_modem,
  output logic       pend,
  output logic [2:0] id
);
  logic tout_eff;
  assign tout_eff = s_tout & fifo_en;

  always_comb begin
    pend = 1'b1;
    id   = ID_MODEM;
    if (s_line)        id = ID_LINE;
    else if (s_rxdat)  id = ID_RXDAT;
    else if (tout_eff) id = ID_TOUT;
    else if (s_thre)   id = ID_THRE;
    else if (s_modem)  id = ID_MODEM;
    else               pend = 1'b0;
  end
endmodule

// File: rtl/uart_iir_hold.sv
module uart_iir_hold
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd,
  input  logic [7:0] live,
  output logic [7:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= IIR_RESET;
    else if (!rd) held <= live;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_wdata,
  input  logic             iir_rd,
  input  logic             src_line,
  input  logic             src_thre,
  input  logic             src_modem,
  input  logic             src_tout,
  input  logic [CNT_W-1:0] rx_count,
  output logic [7:0]       iir_data,
  output logic             irq,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic             fifo_en,
  output logic [CNT_W-1:0] rx_trig_bytes
);
  logic [1:0] trig_code;
  logic       rx_ready;
  logic       rank_pend;
  logic [2:0] rank_id;
  logic [7:0] live_iir;

  uart_fcr_regs u_fcr (
    .clk(clk), .rst_n(rst_n), .wr(fcr_wr), .wdata(fcr_wdata),
    .fifo_en(fifo_en), .trig_code(trig_code),
    .rx_flush(rx_flush), .tx_flush(tx_flush)
  );

  assign rx_trig_bytes = CNT_W'(trig_bytes(trig_code));
  assign rx_ready = fifo_en ? (32'(rx_count) >= trig_bytes(trig_code))
                            : (rx_count != '0);

  uart_irq_rank u_rank (
    .fifo_en(fifo_en), .s_line(src_line), .s_rxdat(rx_ready),
    .s_tout(src_tout), .s_thre(src_thre), .s_modem(src_modem),
    .pend(rank_pend), .id(rank_id)
  );

  assign live_iir = iir_pack(fifo_en, rank_pend, rank_id);
  assign irq      = rank_pend;

  uart_iir_hold u_hold (
    .clk(clk), .rst_n(rst_n), .rd(iir_rd), .live(live_iir), .held(iir_data)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fcr_wr,
  input logic [7:0]       fcr_wdata,
  input logic             iir_rd,
  input logic             src_line,
  input logic [CNT_W-1:0] rx_count,
  input logic [7:0]       iir_data,
  input logic [7:0]       live_iir,
  input logic             irq,
  input logic             rx_flush,
  input logic             tx_flush,
  input logic             fifo_en,
  input logic [CNT_W-1:0] rx_trig_bytes
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_line_top: assert property (@(posedge clk) disable iff (!rst_n)
    src_line |-> (irq && live_iir[3:1] == 3'b011));

  a_r2_bit0_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(iir_rd)) |-> (iir_data[0] == !$past(irq)));

  a_r3_no_tout_nonfifo: assert property (@(posedge clk) disable iff (!rst_n)
    !iir_data[7] |-> !iir_data[3]);

  a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_data[5:4] == 2'b00) && (iir_data[7] == iir_data[6]));

  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd |=> $stable(iir_data));

  a_r6_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rx_flush) |-> ($past(fcr_wr) && $past(fcr_wdata[1])));

  a_r7_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && tx_flush) |-> ($past(fcr_wr) && $past(fcr_wdata[2])));

  a_r8_level_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_count >= rx_trig_bytes) |-> irq);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
  .iir_rd(iir_rd), .src_line(src_line), .rx_count(rx_count),
  .iir_data(iir_data), .live_iir(live_iir), .irq(irq),
  .rx_flush(rx_flush), .tx_flush(tx_flush), .fifo_en(fifo_en),
  .rx_trig_bytes(rx_trig_bytes)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcr_wr = 1'b0;
  logic [7:0] fcr_wdata = 8'h00;
  logic iir_rd = 1'b0;
  logic src_line = 1'b0, src_thre = 1'b0, src_modem = 1'b0, src_tout = 1'b0;
  logic [CW-1:0] rx_count = '0;
  logic [7:0] iir_data;
  logic irq, rx_flush, tx_flush, fifo_en;
  logic [CW-1:0] rx_trig_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .iir_rd(iir_rd), .src_line(src_line), .src_thre(src_thre),
    .src_modem(src_modem), .src_tout(src_tout), .rx_count(rx_count),
    .iir_data(iir_data), .irq(irq), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .fifo_en(fifo_en), .rx_trig_bytes(rx_trig_bytes)
  );

  typedef struct {
    string         tag;
    logic [7:0]    iir;
    logic          irq;
    logic          rxf;
    logic          txf;
    logic          fen;
    logic [CW-1:0] trig;
  } item_t;

  item_t q[$];
  int checks = 0;
  int bad = 0;

  // bench-side state
  logic       m_fen = 1'b0;
  logic [1:0] m_code = 2'b00;
  logic [7:0] exp_iir = 8'h01;

  function automatic int lvl(input logic [1:0] c);
    int t[4] = '{1, 4, 8, 14};
    return t[c];
  endfunction

  function automatic logic [7:0] model(input logic fen, input logic [1:0] c);
    logic [7:0] v;
    logic dr;
    v  = fen ? 8'hC0 : 8'h00;
    dr = fen ? (int'(rx_count) >= lvl(c)) : (rx_count > 0);
    if (src_line)              v = v + 8'd6;
    else if (dr)               v = v + 8'd4;
    else if (fen && src_tout)  v = v + 8'd12;
    else if (src_thre)         v = v + 8'd2;
    else if (src_modem)        v = v + 8'd0;
    else                       v = v + 8'd1;
    return v;
  endfunction

  task automatic step(input string tag, input bit wr, input logic [7:0] wd,
                      input bit rd);
    item_t it;
    logic [7:0] now_v;
    fcr_wr = wr; fcr_wdata = wd; iir_rd = rd;
    if (!rd) exp_iir = model(m_fen, m_code);
    if (wr) begin m_fen = wd[0]; m_code = wd[7:6]; end
    now_v   = model(m_fen, m_code);
    it.tag  = tag;
    it.iir  = exp_iir;
    it.irq  = ~now_v[0];
    it.rxf  = wr & wd[1];
    it.txf  = wr & wd[2];
    it.fen  = m_fen;
    it.trig = CW'(lvl(m_code));
    @(posedge clk);
    #1 q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({iir_data, irq, rx_flush, tx_flush, fifo_en, rx_trig_bytes} !==
            {it.iir, it.irq, it.rxf, it.txf, it.fen, it.trig}) begin
          bad++;
          $display("FAIL %s: iir=%h irq=%b rxf=%b txf=%b fen=%b trig=%0d | expected iir=%h irq=%b rxf=%b txf=%b fen=%b trig=%0d",
                   it.tag, iir_data, irq, rx_flush, tx_flush, fifo_en, rx_trig_bytes,
                   it.iir, it.irq, it.rxf, it.txf, it.fen, it.trig);
        end
      end
    end
  end

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({iir_data, rx_flush, tx_flush, fifo_en, rx_trig_bytes} !== {8'h01, 3'b000, CW'(1)}) begin
      bad++;
      $display("FAIL R11 reset: iir=%h rxf=%b txf=%b fen=%b trig=%0d expected 01/0/0/0/1",
               iir_data, rx_flush, tx_flush, fifo_en, rx_trig_bytes);
    end
    @(negedge clk); rst_n = 1'b1; #1;

    step("R11 idle after reset", 0, 8'h00, 0);
    src_modem = 1;                     step("R1 modem only", 0, 8'h00, 0);
    src_thre = 1;                      step("R1 thre over modem", 0, 8'h00, 0);
    rx_count = 1;                      step("R9 count nonzero nonfifo", 0, 8'h00, 0);
    src_line = 1;                      step("R1 line over all", 0, 8'h00, 0);
    src_line = 0; src_thre = 0; src_modem = 0; rx_count = 0; src_tout = 1;
                                       step("R3 timeout ignored nonfifo", 0, 8'h00, 0);
    src_tout = 0;
    step("R6 R7 flush both, fifo on", 1, 8'h07, 0);
    step("R6 pulse ends, R2 idle fifo", 0, 8'h00, 0);
    step("R8 trig code 01", 1, 8'h41, 0);
    rx_count = 3;                      step("R8 below 4", 0, 8'h00, 0);
    rx_count = 4;                      step("R8 at 4", 0, 8'h00, 0);
    step("R8 trig code 10", 1, 8'h81, 0);
    rx_count = 7;                      step("R8 below 8", 0, 8'h00, 0);
    rx_count = 8;                      step("R8 at 8", 0, 8'h00, 0);
    step("R8 trig code 11", 1, 8'hC1, 0);
    rx_count = 13;                     step("R8 below 14", 0, 8'h00, 0);
    rx_count = 14;                     step("R8 at 14", 0, 8'h00, 0);
    src_tout = 1;                      step("R1 data ready over timeout", 0, 8'h00, 0);
    rx_count = 0; src_thre = 1;        step("R3 timeout over thre", 0, 8'h00, 0);
    src_tout = 0;                      step("R1 thre fifo", 0, 8'h00, 0);
    step("R10 ignored bits 5..3", 1, 8'hF9, 0);
    step("R10 after ignored write", 0, 8'h00, 0);
    step("R6 rx flush only", 1, 8'hC3, 0);
    step("R7 tx flush only", 1, 8'hC5, 0);
    src_thre = 0; src_line = 1;        step("R5 line before read", 0, 8'h00, 0);
                                       step("R5 read start", 0, 8'h00, 1);
    src_line = 0; src_thre = 1;        step("R5 held during read", 0, 8'h00, 1);
    src_thre = 0;                      step("R5 still held", 0, 8'h00, 1);
                                       step("R5 update after read", 0, 8'h00, 0);
    step("R4 fifo off clears mode bits", 1, 8'h00, 0);
    src_modem = 1;                     step("R4 modem nonfifo", 0, 8'h00, 0);
    finish_run();
  end
endmodule